// File: doc/BRIEF.md
# Configurable 8-bit Timer/Counter with Prescaler

This block is an 8-bit up-counter for a microcontroller-style peripheral set. It advances either once per instruction cycle (the internal time base) or on edges of one of two external signals, and an optional power-of-two prescaler can be placed between the chosen source and the counter. Software may load the count at any time; a load freezes the count path for the next two instruction cycles. This lets software add two to the value it writes if it wants a seamless time base.

The block runs on one system clock. An instruction-cycle enable (`cyc_en`), produced elsewhere at one quarter of the system clock, paces all counting. External inputs are sampled on that enable through a two-stage synchroniser. An edge-polarity select picks rising or falling transitions. When the count wraps from 0xFF to 0x00, a sticky flag is raised for the interrupt logic and a one-clock pulse is sent to a neighbouring timer, which can use it as a gate.

Top module: `tc8_timer`

## Requirements
- R1: While `rst_n` is low, `cnt_q` is 0x00 and `ovf_flag` and `ovf_pulse` are 0, and the prescaler and write hold-off are cleared.
- R2: With `cfg_mode`=0 (internal) and `cfg_pre_bypass`=1, `cnt_q` increases by one on each system clock edge at which `cyc_en` is 1, and holds on every edge at which `cyc_en` is 0.
- R3: An increment from 0xFF gives 0x00, sets `ovf_flag`, and drives `ovf_pulse` high for exactly the one clock that follows the wrapping edge.
- R4: `ovf_flag` stays set until an edge with `flag_clr`=1. If a wrap and `flag_clr` land on the same edge, the flag stays set.
- R5: An edge with `wr_cnt`=1 loads `wr_data` into `cnt_q`. The next two `cyc_en` edges do not advance the count, and the third one does.
- R6: With `cfg_pre_bypass`=0 and `cfg_pre_ratio`=N (0..7), the counter advances once per 2^(N+1) source ticks (1:2 up to 1:256). A count write clears the partial prescale.
- R7: With `cfg_mode`=1 and `cfg_alt_src`=0, each qualifying edge of `ext_pin` adds one count. A level first sampled at enable edge k is counted at enable edge k+2.
- R8: `cfg_fall_edge`=0 counts rising transitions of the source, and 1 counts falling transitions only.
- R9: With `cfg_mode`=1 and `cfg_alt_src`=1 the count follows `ext_alt`, and `ext_pin` has no effect. With `cfg_mode`=0 neither external input has any effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| cyc_en | input | 1 | Instruction-cycle enable, one clock in four |
| cfg_mode | input | 1 | 0 = internal instruction cycles, 1 = external edges |
| cfg_alt_src | input | 1 | External source select: 0 = `ext_pin`, 1 = `ext_alt` |
| cfg_fall_edge | input | 1 | 0 = rising edges, 1 = falling edges |
| cfg_pre_bypass | input | 1 | 1 = prescaler bypassed |
| cfg_pre_ratio | input | 3 | Prescale N, divide by 2^(N+1) |
| ext_pin | input | 1 | External pin count input |
| ext_alt | input | 1 | Alternate oscillator count input |
| wr_cnt | input | 1 | Count-register write strobe |
| wr_data | input | 8 | Value loaded on write |
| flag_clr | input | 1 | Clears the overflow flag |
| cnt_q | output | 8 | Current count |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_pulse | output | 1 | One-clock pulse on each wrap |

## Verification
The assertions assume that `cyc_en` is high for at most one clock in every run of clocks, and that configuration changes only while the count is being discarded, meaning a write follows before any count is checked. The stimulus drives `cyc_en` as a single-clock strobe every four clocks. It holds each external level for at least two instruction cycles, which satisfies the synchroniser's sampling. After every change of source, polarity or prescale it waits four instruction cycles and reloads the count. Expected counts are computed as pulse totals shifted by the prescale exponent, and the sweeps cover all eight ratios, both sources and both polarities.

// File: rtl/tc8_pkg.sv
package tc8_pkg;
  typedef enum logic {
    SRC_INTERNAL = 1'b0,
    SRC_EXTERNAL = 1'b1
  } tc8_src_e;

  localparam int unsigned TC8_HOLD_CYCLES = 2;
  localparam int unsigned TC8_SYNC_DEPTH  = 2;
endpackage

// File: rtl/tc8_edge_sync.sv
module tc8_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic din,
  output logic tick
);
  logic [STAGES-1:0] sh_q, sh_d;
  logic              prev_q, prev_d;

  always_comb begin
    sh_d   = sh_q;
    prev_d = prev_q;
    if (en) begin
      sh_d   = {sh_q[STAGES-2:0], din};
      prev_d = sh_q[STAGES-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      prev_q <= prev_d;
    end
  end

  assign tick = en & sh_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/tc8_prescaler.sv
module tc8_prescaler #(
  parameter int unsigned PRE_W = 8,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick_in,
  input  logic             bypass,
  input  logic [SEL_W-1:0] ratio,
  output logic             tick_out
);
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PRE_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) begin
      mask[i] = (i <= int'(ratio));
    end
  end

  always_comb begin
    pre_d = pre_q;
    if (clr) begin
      pre_d = '0;
    end else if (tick_in && !bypass) begin
      pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_d;
    end
  end

  assign tick_out = bypass ? tick_in : (tick_in && ((pre_q & mask) == mask));
endmodule

// File: rtl/tc8_timer.sv
module tc8_timer
  import tc8_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned SEL_W     = 3,
  parameter int unsigned HOLD_CYC  = TC8_HOLD_CYCLES,
  parameter int unsigned SYNC_DPTH = TC8_SYNC_DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_en,
  input  logic             cfg_mode,
  input  logic             cfg_alt_src,
  input  logic             cfg_fall_edge,
  input  logic             cfg_pre_bypass,
  input  logic [SEL_W-1:0] cfg_pre_ratio,
  input  logic             ext_pin,
  input  logic             ext_alt,
  input  logic             wr_cnt,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_flag,
  output logic             ovf_pulse
);
  localparam int unsigned PRE_W  = 1 << SEL_W;
  localparam int unsigned HOLD_W = $clog2(HOLD_CYC + 1);

  tc8_src_e          src_sel;
  logic              ext_raw, ext_pol, ext_tick;
  logic              src_tick, gated_tick, inc;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic              holding;
  logic [CNT_W-1:0]  cnt_d;
  logic              flag_d, pulse_d, wrap;

  assign src_sel = tc8_src_e'(cfg_mode);
  assign ext_raw = cfg_alt_src ? ext_alt : ext_pin;
  assign ext_pol = ext_raw ^ cfg_fall_edge;

  tc8_edge_sync #(.STAGES(SYNC_DPTH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (cyc_en),
    .din   (ext_pol),
    .tick  (ext_tick)
  );

  assign holding    = (hold_q != '0);
  assign src_tick   = (src_sel == SRC_EXTERNAL) ? ext_tick : cyc_en;
  assign gated_tick = src_tick & ~holding & ~wr_cnt;

  tc8_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (wr_cnt),
    .tick_in  (gated_tick),
    .bypass   (cfg_pre_bypass),
    .ratio    (cfg_pre_ratio),
    .tick_out (inc)
  );

  assign wrap = inc & (cnt_q == {CNT_W{1'b1}});

  always_comb begin
    cnt_d   = cnt_q;
    hold_d  = hold_q;
    flag_d  = ovf_flag;
    pulse_d = wrap;
    if (wr_cnt) begin
      cnt_d  = wr_data;
      hold_d = HOLD_W'(HOLD_CYC);
    end else begin
      if (inc) begin
        cnt_d = cnt_q + 1'b1;
      end
      if (cyc_en && holding) begin
        hold_d = hold_q - 1'b1;
      end
    end
    if (wrap) begin
      flag_d = 1'b1;
    end else if (flag_clr) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      hold_q    <= '0;
      ovf_flag  <= 1'b0;
      ovf_pulse <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      hold_q    <= hold_d;
      ovf_flag  <= flag_d;
      ovf_pulse <= pulse_d;
    end
  end
endmodule

// File: rtl/tc8_timer_chk.sv
module tc8_timer_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cyc_en,
  input logic             wr_cnt,
  input logic [CNT_W-1:0] wr_data,
  input logic             flag_clr,
  input logic [CNT_W-1:0] cnt_q,
  input logic             ovf_flag,
  input logic             ovf_pulse
);
  logic [1:0] since_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_wr <= 2'd3;
    end else if (wr_cnt) begin
      since_wr <= 2'd0;
    end else if (cyc_en && since_wr != 2'd3) begin
      since_wr <= since_wr + 2'd1;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_state: assert (cnt_q == '0 && !ovf_flag && !ovf_pulse);
    end
  end

  a_r2_hold_off_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_en && !wr_cnt) |=> $stable(cnt_q));

  a_r3_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> !ovf_pulse);

  a_r3_pulse_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> (cnt_q == '0 && ovf_flag));

  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clr) |=> ovf_flag);

  a_r4_flag_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> ovf_pulse);

  a_r5_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (cnt_q == $past(wr_data)));

  a_r5_hold_two: assert property (@(posedge clk) disable iff (!rst_n)
    (since_wr < 2'd2 && cyc_en && !wr_cnt) |=> $stable(cnt_q));
endmodule

bind tc8_timer tc8_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cyc_en    (cyc_en),
  .wr_cnt    (wr_cnt),
  .wr_data   (wr_data),
  .flag_clr  (flag_clr),
  .cnt_q     (cnt_q),
  .ovf_flag  (ovf_flag),
  .ovf_pulse (ovf_pulse)
);

// File: tb/tc8_timer_test.sv
module tc8_timer_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cyc_en, cfg_mode, cfg_alt_src, cfg_fall_edge, cfg_pre_bypass;
  logic [2:0] cfg_pre_ratio;
  logic       ext_pin, ext_alt, wr_cnt, flag_clr;
  logic [7:0] wr_data;
  logic [7:0] cnt_q;
  logic       ovf_flag, ovf_pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  tc8_timer uut (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .cfg_mode(cfg_mode),
    .cfg_alt_src(cfg_alt_src), .cfg_fall_edge(cfg_fall_edge),
    .cfg_pre_bypass(cfg_pre_bypass), .cfg_pre_ratio(cfg_pre_ratio),
    .ext_pin(ext_pin), .ext_alt(ext_alt), .wr_cnt(wr_cnt), .wr_data(wr_data),
    .flag_clr(flag_clr), .cnt_q(cnt_q), .ovf_flag(ovf_flag), .ovf_pulse(ovf_pulse)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ic(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) cyc_en = 1'b1;
      @(negedge clk) cyc_en = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic load(input logic [7:0] v);
    @(negedge clk) begin wr_cnt = 1'b1; wr_data = v; end
    @(negedge clk) wr_cnt = 1'b0;
  endtask

  task automatic pulse_pin(input bit use_alt, input int n);
    for (int i = 0; i < n; i++) begin
      if (use_alt) begin ext_alt = 1'b1; ext_pin = 1'b0; end
      else begin ext_pin = 1'b1; ext_alt = 1'b1; end
      ic(2);
      if (use_alt) begin ext_alt = 1'b0; ext_pin = 1'b1; end
      else begin ext_pin = 1'b0; ext_alt = 1'b0; end
      ic(2);
    end
    ext_pin = 1'b0;
    ext_alt = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cyc_en = 1'b0; cfg_mode = 1'b0; cfg_alt_src = 1'b0;
    cfg_fall_edge = 1'b0; cfg_pre_bypass = 1'b1; cfg_pre_ratio = 3'd0;
    ext_pin = 1'b0; ext_alt = 1'b0; wr_cnt = 1'b0; flag_clr = 1'b0; wr_data = 8'h00;
    repeat (4) @(negedge clk);
    check("R1 count", cnt_q, 0);
    check("R1 flag", ovf_flag, 0);
    check("R1 pulse", ovf_pulse, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 and R2: timer mode, bypassed prescaler
    load(8'h10);
    check("R5 load", cnt_q, 8'h10);
    ic(2);
    check("R5 hold two", cnt_q, 8'h10);
    for (int i = 1; i <= 20; i++) begin
      ic(1);
      check("R2 per cycle", cnt_q, 8'h10 + i);
    end
    @(negedge clk);
    check("R2 no enable", cnt_q, 8'h24);

    // R3 overflow
    load(8'hFD);
    ic(2);
    ic(2);
    check("R3 pre-wrap", cnt_q, 8'hFF);
    check("R3 flag low", ovf_flag, 0);
    @(negedge clk) cyc_en = 1'b1;
    @(negedge clk) cyc_en = 1'b0;
    check("R3 wrap value", cnt_q, 0);
    check("R3 pulse high", ovf_pulse, 1);
    check("R3 flag set", ovf_flag, 1);
    @(negedge clk);
    check("R3 pulse width", ovf_pulse, 0);
    @(negedge clk);

    // R4 sticky flag
    ic(5);
    check("R4 sticky", ovf_flag, 1);
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
    check("R4 cleared", ovf_flag, 0);
    load(8'hFF);
    ic(2);
    @(negedge clk) begin cyc_en = 1'b1; flag_clr = 1'b1; end
    @(negedge clk) begin cyc_en = 1'b0; flag_clr = 1'b0; end
    check("R4 set wins", ovf_flag, 1);
    check("R4 wrap count", cnt_q, 0);
    repeat (2) @(negedge clk);

    // R9: externals ignored in timer mode
    load(8'h00);
    ic(2);
    for (int i = 0; i < 6; i++) begin
      ext_pin = ~ext_pin;
      ext_alt = ~ext_alt;
      ic(1);
    end
    check("R9 timer ignores ext", cnt_q, 6);
    ext_pin = 1'b0;
    ext_alt = 1'b0;

    // R6 prescaler sweep, all ratios
    cfg_pre_bypass = 1'b0;
    for (int n = 0; n < 8; n++) begin
      cfg_pre_ratio = 3'(n);
      load(8'h00);
      ic(2);
      ic(3 * (2 << n) - 1);
      check("R6 below step", cnt_q, 2);
      ic(1);
      check("R6 at step", cnt_q, 3);
    end
    cfg_pre_ratio = 3'd2;
    load(8'h00);
    ic(2);
    ic(5);
    load(8'h40);
    ic(2);
    ic(7);
    check("R6 cleared by write", cnt_q, 8'h40);
    ic(1);
    check("R6 after clear", cnt_q, 8'h41);
    cfg_pre_bypass = 1'b1;

    // R7 counter mode, pin source, rising
    cfg_mode = 1'b1;
    ic(4);
    load(8'h00);
    ic(2);
    pulse_pin(1'b0, 5);
    ic(3);
    check("R7 pin edges", cnt_q, 5);
    ext_pin = 1'b1;
    ic(2);
    check("R7 latency before", cnt_q, 5);
    ic(1);
    check("R7 latency at", cnt_q, 6);
    ext_pin = 1'b0;
    ic(3);

    // R9 alternate source
    cfg_alt_src = 1'b1;
    ic(4);
    load(8'h00);
    ic(2);
    pulse_pin(1'b1, 3);
    ic(3);
    check("R9 alt source", cnt_q, 3);
    cfg_alt_src = 1'b0;

    // R8 falling edges
    cfg_fall_edge = 1'b1;
    ic(4);
    load(8'h00);
    ic(2);
    pulse_pin(1'b0, 4);
    ic(3);
    check("R8 falling count", cnt_q, 4);
    ext_pin = 1'b1;
    ic(3);
    check("R8 rise ignored", cnt_q, 4);
    ext_pin = 1'b0;
    ic(2);
    check("R8 fall before", cnt_q, 4);
    ic(1);
    check("R8 fall counted", cnt_q, 5);
    cfg_fall_edge = 1'b0;

    // R6 with external source
    cfg_pre_bypass = 1'b0;
    cfg_pre_ratio = 3'd0;
    ic(4);
    load(8'h00);
    ic(2);
    pulse_pin(1'b0, 6);
    ic(3);
    check("R6 external prescale", cnt_q, 3);

    finish_run();
  end
endmodule